// File: doc/BRIEF.md
# Reservation Monitor for Atomic Read-Modify-Write

This block keeps one reservation for a load-linked / store-conditional style atomic sequence. A reserving load presents its address and access length. The monitor remembers them together with a valid flag. A later conditional store presents its address. The monitor then decides, in the same cycle, whether the memory write may go ahead. It always reports the outcome one cycle later as a 4-bit status nibble.

Any conditional store consumes the reservation, whether it succeeds or not. A reserving load replaces whatever was held before. An external kill input drops the reservation at once. The kill input wins over a reserving load that arrives in the same cycle. It also makes a conditional store in that cycle fail.

The monitor also passes the loaded word back to the core, sign-extended to the register width. Memory and coherence snooping sit outside the block.

Top module: `lrsc_monitor`

## Requirements
- R1: After synchronous reset no reservation is held: `rsp_valid` and `st_en` are 0, and a conditional store to any address (including address 0) does not assert `st_en`.
- R2: A reserving load (`req_kind` = 2'b01) of length 4 at address A, followed by a conditional store (`req_kind` = 2'b10) to A, asserts `st_en` combinationally in the cycle of the store request.
- R3: A conditional store whose address differs from the reserved address does not assert `st_en`.
- R4: A reservation recorded with a length other than 4 bytes never lets a conditional store succeed, even at the same address.
- R5: Every conditional store, successful or not, clears the reservation, so a second conditional store to the same address without a new reserving load fails.
- R6: `rsp_valid` is high for exactly one cycle, the cycle after each conditional store request. In that cycle `rsp_status` is {2'b00, success, so}: bit 1 is set when the store was allowed, bit 0 copies `so_in` as sampled with the request, and bits 3:2 are zero (values 0x0, 0x1, 0x2 or 0x3).
- R7: A new reserving load overwrites any held reservation: only the latest reserved address can succeed.
- R8: `invalidate` clears the reservation. It takes priority over a reserving load in the same cycle, which is then dropped. A conditional store in the same cycle as `invalidate` fails.
- R9: `ld_ext` equals `ld_word` sign-extended from bit 31 to XLEN (64) bits.
- R10: `st_en` is never asserted, and no response is produced, for idle (2'b00, 2'b11) or reserving-load requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_kind | input | 2 | 00 idle, 01 reserving load, 10 conditional store, 11 idle |
| req_addr | input | 32 | Effective address of the request |
| req_len | input | 4 | Access length in bytes (used by reserving load) |
| so_in | input | 1 | Summary-overflow flag folded into the status |
| invalidate | input | 1 | Drop the reservation this cycle |
| ld_word | input | 32 | Word returned by memory for the load |
| st_en | output | 1 | Memory write allowed for the current conditional store |
| rsp_valid | output | 1 | One-cycle strobe after a conditional store |
| rsp_status | output | 4 | Status nibble {00, success, so} |
| ld_ext | output | 64 | Sign-extended load result |

## Verification
The store check runs against several histories. One is a matching word reservation, which is the only case that may pass. The others are a mismatched address, a reservation of the wrong length, and a reservation already consumed by an earlier store. Two more sequences cover a reservation replaced by a newer load and reservations killed by `invalidate`, both alone and together with a load or a store. Each of these isolates one term of the match condition or one way the reservation is cleared. The status nibble is checked with `so_in` both low and high, so the success and overflow bits are told apart. The sign extension is checked with both a negative and a positive word.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        REQ_IDLE       = 2'b00,
        REQ_LOAD_RSV   = 2'b01,
        REQ_STORE_COND = 2'b10,
        REQ_SPARE      = 2'b11
    } req_kind_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       success;
        logic       so;
    } status_t;

    function automatic status_t make_status(input logic success, input logic so);
        status_t s;
        s.rsvd    = 2'b00;
        s.success = success;
        s.so      = so;
        return s;
    endfunction

endpackage

// File: rtl/lrsc_rsv_reg.sv
module lrsc_rsv_reg #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              clr,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [LEN_W-1:0]  set_len,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  len
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            len   <= '0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (set) begin
            valid <= 1'b1;
            addr  <= set_addr;
            len   <= set_len;
        end
    end
endmodule

// File: rtl/lrsc_match.sv
module lrsc_match #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 4,
    parameter int WORD_BYTES = 4
) (
    input  logic              rsv_valid,
    input  logic [ADDR_W-1:0] rsv_addr,
    input  logic [LEN_W-1:0]  rsv_len,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              kill,
    output logic              hit
);
    localparam logic [LEN_W-1:0] WORD_LEN = LEN_W'(WORD_BYTES);

    always_comb begin
        hit = rsv_valid && !kill && (rsv_len == WORD_LEN) && (rsv_addr == sc_addr);
    end
endmodule

// File: rtl/lrsc_rsp.sv
module lrsc_rsp
    import lrsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fire,
    input  logic    success,
    input  logic    so,
    output logic    rsp_valid,
    output status_t rsp_status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_status <= '0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_status <= make_status(success, so);
            end
        end
    end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4,
    parameter int WORD_W = 32,
    parameter int XLEN   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              so_in,
    input  logic              invalidate,
    input  logic [WORD_W-1:0] ld_word,
    output logic              st_en,
    output logic              rsp_valid,
    output logic [3:0]        rsp_status,
    output logic [XLEN-1:0]   ld_ext
);
    localparam int WORD_BYTES = WORD_W / 8;

    req_kind_e         kind;
    logic              is_lr;
    logic              is_sc;
    logic              rsv_valid;
    logic [ADDR_W-1:0] rsv_addr;
    logic [LEN_W-1:0]  rsv_len;
    logic              hit;
    status_t           status_q;

    assign kind  = req_kind_e'(req_kind);
    assign is_lr = (kind == REQ_LOAD_RSV);
    assign is_sc = (kind == REQ_STORE_COND);

    lrsc_rsv_reg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rsv (
        .clk      (clk),
        .rst      (rst),
        .set      (is_lr && !invalidate),
        .clr      (is_sc || invalidate),
        .set_addr (req_addr),
        .set_len  (req_len),
        .valid    (rsv_valid),
        .addr     (rsv_addr),
        .len      (rsv_len)
    );

    lrsc_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)) u_match (
        .rsv_valid (rsv_valid),
        .rsv_addr  (rsv_addr),
        .rsv_len   (rsv_len),
        .sc_addr   (req_addr),
        .kill      (invalidate),
        .hit       (hit)
    );

    assign st_en = is_sc && hit;

    lrsc_rsp u_rsp (
        .clk        (clk),
        .rst        (rst),
        .fire       (is_sc),
        .success    (st_en),
        .so         (so_in),
        .rsp_valid  (rsp_valid),
        .rsp_status (status_q)
    );

    assign rsp_status = status_q;

    generate
        if (XLEN > WORD_W) begin : g_ext
            assign ld_ext = {{(XLEN-WORD_W){ld_word[WORD_W-1]}}, ld_word};
        end else begin : g_same
            assign ld_ext = ld_word[XLEN-1:0];
        end
    endgenerate
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] req_kind,
    input logic       so_in,
    input logic       invalidate,
    input logic       st_en,
    input logic       rsp_valid,
    input logic [3:0] rsp_status
);
    // R10
    st_en_only_on_sc_chk: assert property (@(posedge clk) disable iff (rst)
        st_en |-> (req_kind == 2'b10));

    // R6
    rsp_after_sc_chk: assert property (@(posedge clk) disable iff (rst)
        (req_kind == 2'b10) |=> rsp_valid);

    // R6
    no_rsp_without_sc_chk: assert property (@(posedge clk) disable iff (rst)
        (req_kind != 2'b10) |=> !rsp_valid);

    // R6
    status_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (req_kind == 2'b10) |=> (rsp_status == {2'b00, $past(st_en), $past(so_in)}));

    // R5
    back_to_back_sc_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (req_kind == 2'b10) |=> ((req_kind != 2'b10) || !st_en));

    // R8
    inval_blocks_now_chk: assert property (@(posedge clk) disable iff (rst)
        invalidate |-> !st_en);

    // R8
    inval_blocks_next_chk: assert property (@(posedge clk) disable iff (rst)
        invalidate |=> !st_en);
endmodule

bind lrsc_monitor lrsc_monitor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_kind   (req_kind),
    .so_in      (so_in),
    .invalidate (invalidate),
    .st_en      (st_en),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status)
);

// File: tb/lrsc_monitor_bench.sv
module lrsc_monitor_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_len = 4'd4;
    logic        so_in = 1'b0;
    logic        invalidate = 1'b0;
    logic [31:0] ld_word = '0;
    logic        st_en;
    logic        rsp_valid;
    logic [3:0]  rsp_status;
    logic [63:0] ld_ext;

    int total = 0;
    int bad = 0;
    logic st_seen;
    logic rv_seen;
    logic [3:0] rs_seen;

    localparam logic [1:0] K_IDLE = 2'b00, K_LR = 2'b01, K_SC = 2'b10;

    always #2.5 clk = ~clk;

    lrsc_monitor u_lrsc_monitor (
        .clk(clk), .rst(rst), .req_kind(req_kind), .req_addr(req_addr),
        .req_len(req_len), .so_in(so_in), .invalidate(invalidate),
        .ld_word(ld_word), .st_en(st_en), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .ld_ext(ld_ext)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; drives one request, returns at the next falling edge
    task automatic issue(input logic [1:0] k, input logic [31:0] a, input logic [3:0] l,
                         input logic so, input logic inv);
        req_kind = k; req_addr = a; req_len = l; so_in = so; invalidate = inv;
        #1;
        st_seen = st_en;
        @(negedge clk);
        rv_seen = rsp_valid;
        rs_seen = rsp_status;
        req_kind = K_IDLE; so_in = 1'b0; invalidate = 1'b0; req_len = 4'd4;
    endtask

    task automatic t_reset();
        check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        check("R1 st_en after reset", {63'd0, st_en}, 64'd0);
        issue(K_SC, 32'h0, 4'd4, 1'b0, 1'b0);
        check("R1 sc with no reservation", {63'd0, st_seen}, 64'd0);
        check("R1 status", {60'd0, rs_seen}, 64'h0);
    endtask

    task automatic t_basic();
        issue(K_LR, 32'h1000, 4'd4, 1'b0, 1'b0);
        check("R10 no st_en on load", {63'd0, st_seen}, 64'd0);
        check("R10 no rsp on load", {63'd0, rv_seen}, 64'd0);
        issue(K_SC, 32'h1000, 4'd4, 1'b0, 1'b0);
        check("R2 matching sc", {63'd0, st_seen}, 64'd1);
        check("R6 rsp_valid", {63'd0, rv_seen}, 64'd1);
        check("R6 status success", {60'd0, rs_seen}, 64'h2);
        issue(K_SC, 32'h1000, 4'd4, 1'b0, 1'b0);
        check("R5 second sc fails", {63'd0, st_seen}, 64'd0);
        check("R5 status fail", {60'd0, rs_seen}, 64'h0);
        issue(K_IDLE, 32'h1000, 4'd4, 1'b0, 1'b0);
        check("R6 strobe one cycle", {63'd0, rv_seen}, 64'd0);
    endtask

    task automatic t_mismatch();
        issue(K_LR, 32'h2000, 4'd4, 1'b0, 1'b0);
        issue(K_SC, 32'h2004, 4'd4, 1'b1, 1'b0);
        check("R3 address mismatch", {63'd0, st_seen}, 64'd0);
        check("R6 status so only", {60'd0, rs_seen}, 64'h1);
        issue(K_SC, 32'h2000, 4'd4, 1'b0, 1'b0);
        check("R5 failed sc also clears", {63'd0, st_seen}, 64'd0);
    endtask

    task automatic t_len();
        issue(K_LR, 32'h3000, 4'd8, 1'b0, 1'b0);
        issue(K_SC, 32'h3000, 4'd4, 1'b0, 1'b0);
        check("R4 length 8 reservation", {63'd0, st_seen}, 64'd0);
        issue(K_LR, 32'h3000, 4'd2, 1'b0, 1'b0);
        issue(K_SC, 32'h3000, 4'd4, 1'b0, 1'b0);
        check("R4 length 2 reservation", {63'd0, st_seen}, 64'd0);
    endtask

    task automatic t_so();
        issue(K_LR, 32'h4000, 4'd4, 1'b0, 1'b0);
        issue(K_SC, 32'h4000, 4'd4, 1'b1, 1'b0);
        check("R6 success with so", {60'd0, rs_seen}, 64'h3);
    endtask

    task automatic t_overwrite();
        issue(K_LR, 32'h5000, 4'd4, 1'b0, 1'b0);
        issue(K_LR, 32'h6000, 4'd4, 1'b0, 1'b0);
        issue(K_SC, 32'h5000, 4'd4, 1'b0, 1'b0);
        check("R7 older address fails", {63'd0, st_seen}, 64'd0);
        issue(K_LR, 32'h5000, 4'd4, 1'b0, 1'b0);
        issue(K_LR, 32'h6000, 4'd4, 1'b0, 1'b0);
        issue(K_SC, 32'h6000, 4'd4, 1'b0, 1'b0);
        check("R7 newest address wins", {63'd0, st_seen}, 64'd1);
    endtask

    task automatic t_inval();
        issue(K_LR, 32'h7000, 4'd4, 1'b0, 1'b0);
        issue(K_IDLE, 32'h0, 4'd4, 1'b0, 1'b1);
        issue(K_SC, 32'h7000, 4'd4, 1'b0, 1'b0);
        check("R8 invalidate clears", {63'd0, st_seen}, 64'd0);
        issue(K_LR, 32'h7000, 4'd4, 1'b0, 1'b0);
        issue(K_LR, 32'h7000, 4'd4, 1'b0, 1'b1);
        issue(K_SC, 32'h7000, 4'd4, 1'b0, 1'b0);
        check("R8 invalidate beats load", {63'd0, st_seen}, 64'd0);
        issue(K_LR, 32'h7000, 4'd4, 1'b0, 1'b0);
        issue(K_SC, 32'h7000, 4'd4, 1'b0, 1'b1);
        check("R8 sc with invalidate", {63'd0, st_seen}, 64'd0);
        check("R8 status", {60'd0, rs_seen}, 64'h0);
    endtask

    task automatic t_sext();
        ld_word = 32'h8000_0001;
        #1;
        check("R9 negative word", ld_ext, 64'hFFFF_FFFF_8000_0001);
        ld_word = 32'h7FFF_FFFF;
        #1;
        check("R9 positive word", ld_ext, 64'h0000_0000_7FFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mismatch();
        t_len();
        t_so();
        t_overwrite();
        t_inval();
        t_sext();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule